// File: doc/BRIEF.md
# Interleaved ADC Output Formatter

This block is the digital tail of a 16-bit pipelined converter model. At the end of every conversion period it captures one raw sample and its over-range flag. It holds them in a fixed eight-period delay line. It then re-codes the sample into one of three number formats and sends it out on half as many lines as there are bits. Each line carries a pair of adjacent bits, one bit in each half of the conversion period. A data clock output marks which half is on the lines.

The block runs on a fast clock at twice the converter input clock. The conversion period is therefore `2*(div_sel+1)` fast cycles. A 3-bit power mode selects between running with the outputs on, running with the outputs silenced, and clearing the delay line. Format and divider selects are static: they are changed only while the block is held in reset.

Top module: `adc_lane_formatter`

## Requirements
- R1: Output line k carries sample bit 2k+1 during the first `div_sel+1` fast cycles of a conversion period and bit 2k during the remaining `div_sel+1` cycles. The pairing runs line 7 = bits 15/14 down to line 0 = bits 1/0.
- R2: After reset the conversion period is `2*(div_sel+1)` fast cycles, with `div_sel` from 0 to 7. `dco` is high during the first half and low during the second half. `smp_take` is high only in the last fast cycle of each period, and only in a mode that keeps the delay line.
- R3: The sample present in period j appears on the lines during period j+8. Before eight samples have been taken after reset, the delay line holds zero words.
- R4: With `fmt_gray` high the output is the Gray code `b ^ (b >> 1)` of the raw word. Otherwise, with `fmt_tc` high, the output is the raw word with bit 15 inverted (twos complement). With both low the raw offset binary word passes unchanged.
- R5: `ovr_out` carries the over-range flag of the same sample whose bits are on the lines, with the same eight-period delay.
- R6: In mode 110 `dout`, `ovr_out` and `dco` are low, but the delay line keeps shifting. After a return to 111 the samples taken during 110 appear at their normal time.
- R7: In modes 100 (power-down) and 101 (standby), and in any code with bit 2 or bit 1 low, the delay line is cleared and the outputs are low. Every sample taken in or before such a period is lost and shows as a zero word.
- R8: While `rst_n` is low, `dout`, `ovr_out`, `dco` and `smp_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the converter input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 3 | Divide ratio minus one (0 = divide by 1, 7 = divide by 8) |
| fmt_tc | input | 1 | Twos complement output when high and Gray is off |
| fmt_gray | input | 1 | Gray code output when high |
| pwr_mode | input | 3 | 111 on, 110 silent, 101 standby, 100 power-down |
| din | input | 16 | Raw offset binary sample |
| din_ovr | input | 1 | Over-range flag of `din` |
| smp_take | output | 1 | High in the fast cycle whose closing edge captures `din` |
| dout | output | 8 | Interleaved bit-pair lines |
| ovr_out | output | 1 | Delayed over-range flag |
| dco | output | 1 | Data clock, high during odd bits |

## Verification
A phase counter that slips shows up within one conversion period as a `dco` edge or a `smp_take` pulse at the wrong fast cycle. A stage of the delay line that drops or repeats a word shifts every later word by a period. This is seen eight periods after the first capture, as lines that carry the neighbouring sample. An incomplete clear leaves a stale word visible in the first eight periods after the block returns to mode 111. A wrong code or pair selection shows up in the very first half-period that carries data.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    CODE_OB   = 2'd0,
    CODE_TC   = 2'd1,
    CODE_GRAY = 2'd2
  } code_e;

  localparam logic [2:0] MODE_ON     = 3'b111;
  localparam logic [2:0] MODE_SILENT = 3'b110;

  // delay line is kept only in the two running modes
  function automatic logic mode_clears(input logic [2:0] m);
    return !(m[2] && m[1]);
  endfunction

  function automatic code_e pick_code(input logic tc, input logic gray);
    if (gray) return CODE_GRAY;
    if (tc) return CODE_TC;
    return CODE_OB;
  endfunction

endpackage

// File: rtl/adc_fmt_divider.sv
module adc_fmt_divider #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick,
  output logic             first_half
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;

  assign last_cnt   = {div_sel, 1'b1};
  assign half_cnt   = {1'b0, div_sel};
  assign tick       = (cnt >= last_cnt);
  assign first_half = (cnt <= half_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay #(
  parameter int W     = 17,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         clear,
  input  logic [W-1:0] d,
  output logic [W-1:0] head,
  output logic [W-1:0] tail
);
  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] feed;
    if (i == 0) begin : g_first
      assign feed = d;
    end else begin : g_rest
      assign feed = stage[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear) stage[i] <= '0;
      else if (shift) stage[i] <= feed;
    end
  end

  assign head = stage[0];
  assign tail = stage[DEPTH-1];
endmodule

// File: rtl/adc_fmt_lanes.sv
module adc_fmt_lanes
  import adc_fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]   word,
  input  code_e          code,
  input  logic           first_half,
  input  logic           drive,
  output logic [W/2-1:0] lines
);
  localparam int LANES = W / 2;

  function automatic logic [W-1:0] recode(input logic [W-1:0] raw, input code_e c);
    case (c)
      CODE_TC:   return {~raw[W-1], raw[W-2:0]};
      CODE_GRAY: return raw ^ (raw >> 1);
      default:   return raw;
    endcase
  endfunction

  function automatic logic [LANES-1:0] pick_half(input logic [W-1:0] w, input logic odd);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = w[2*k + (odd ? 1 : 0)];
    return r;
  endfunction

  assign lines = drive ? pick_half(recode(word, code), first_half) : '0;
endmodule

// File: rtl/adc_lane_formatter.sv
module adc_lane_formatter
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LATENCY  = 8,
  parameter int MAX_DIV  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAX_DIV)-1:0]    div_sel,
  input  logic                          fmt_tc,
  input  logic                          fmt_gray,
  input  logic [2:0]                    pwr_mode,
  input  logic [SAMPLE_W-1:0]           din,
  input  logic                          din_ovr,
  output logic                          smp_take,
  output logic [SAMPLE_W/2-1:0]         dout,
  output logic                          ovr_out,
  output logic                          dco
);
  localparam int DIV_W = $clog2(MAX_DIV);
  localparam int WORD_W = SAMPLE_W + 1;

  logic              tick;
  logic              first_half;
  logic              clear_pipe;
  logic              out_on;
  logic [WORD_W-1:0] head_word;
  logic [WORD_W-1:0] tail_word;
  code_e             code_sel;

  assign clear_pipe = mode_clears(pwr_mode);
  assign out_on     = rst_n && (pwr_mode == MODE_ON);
  assign code_sel   = pick_code(fmt_tc, fmt_gray);

  adc_fmt_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .tick       (tick),
    .first_half (first_half)
  );

  adc_fmt_delay #(.W(WORD_W), .DEPTH(LATENCY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (tick),
    .clear (clear_pipe),
    .d     ({din_ovr, din}),
    .head  (head_word),
    .tail  (tail_word)
  );

  adc_fmt_lanes #(.W(SAMPLE_W)) u_lanes (
    .word       (tail_word[SAMPLE_W-1:0]),
    .code       (code_sel),
    .first_half (first_half),
    .drive      (out_on),
    .lines      (dout)
  );

  assign smp_take = rst_n && tick && !clear_pipe;
  assign dco      = out_on && first_half;
  assign ovr_out  = out_on && tail_word[SAMPLE_W];
endmodule

// File: rtl/adc_fmt_checker.sv
module adc_fmt_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            pwr_mode,
  input logic [SAMPLE_W-1:0]   din,
  input logic                  din_ovr,
  input logic [SAMPLE_W/2-1:0] dout,
  input logic                  ovr_out,
  input logic                  dco,
  input logic                  tick,
  input logic                  first_half,
  input logic                  clear_pipe,
  input logic [SAMPLE_W:0]     head_word,
  input logic [SAMPLE_W:0]     tail_word
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2
  AST_PERIOD_OPENS: assert property (@(posedge clk) disable iff (!rst_n) tick |=> first_half); // R2
  AST_EVEN_DCO_LOW: assert property (@(posedge clk) disable iff (!rst_n) !first_half |-> !dco); // R2
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear_pipe) |=> head_word == $past({din_ovr, din})); // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pipe |=> tail_word == '0); // R7
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 3'b111) |-> (dout == '0 && !dco && !ovr_out)); // R6
endmodule

bind adc_lane_formatter adc_fmt_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_mode   (pwr_mode),
  .din        (din),
  .din_ovr    (din_ovr),
  .dout       (dout),
  .ovr_out    (ovr_out),
  .dco        (dco),
  .tick       (tick),
  .first_half (first_half),
  .clear_pipe (clear_pipe),
  .head_word  (head_word),
  .tail_word  (tail_word)
);

// File: tb/sim_adc_lane_formatter.sv
module sim_adc_lane_formatter;
  localparam int NP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = '0;
  logic        fmt_tc = 1'b0;
  logic        fmt_gray = 1'b0;
  logic [2:0]  pwr_mode = 3'b111;
  logic [15:0] din = '0;
  logic        din_ovr = 1'b0;
  logic        smp_take;
  logic [7:0]  dout;
  logic        ovr_out;
  logic        dco;

  int checks = 0;
  int errors = 0;
  logic [16:0] hist [NP];

  always #2 clk = ~clk;

  adc_lane_formatter u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .fmt_tc(fmt_tc), .fmt_gray(fmt_gray),
    .pwr_mode(pwr_mode), .din(din), .din_ovr(din_ovr), .smp_take(smp_take),
    .dout(dout), .ovr_out(ovr_out), .dco(dco)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] gen_word(input int p, input int dv, input int f);
    logic [16:0] w;
    case (p)
      0: w = {1'b0, 16'h0000};
      1: w = {1'b1, 16'hFFFF};
      2: w = {1'b0, 16'h8000};
      3: w = {1'b1, 16'h7FFF};
      default: w = 17'((p * 40503 + dv * 977 + f * 8191 + 12345) & 32'h1FFFF);
    endcase
    return w;
  endfunction

  // format: 0 offset binary, 1 twos complement, 2/3 Gray
  function automatic logic [7:0] ref_lines(input logic [15:0] raw, input int f, input bit odd);
    logic [15:0] c;
    logic [7:0] r;
    if (f >= 2) begin
      for (int i = 0; i < 16; i++) c[i] = (i == 15) ? raw[15] : (raw[i] ^ raw[i+1]);
    end else if (f == 1) c = 16'(raw + 16'h8000);
    else c = raw;
    for (int k = 0; k < 8; k++) r[k] = odd ? c[2*k+1] : c[2*k];
    return r;
  endfunction

  function automatic logic [2:0] mode_for(input int sc, input int p);
    case (sc)
      1: return (p == 9 || p == 10) ? 3'b110 : 3'b111;
      2: return (p == 10 || p == 11) ? 3'b101 : 3'b111;
      3: return (p == 10) ? 3'b100 : ((p == 14) ? 3'b011 : 3'b111);
      default: return 3'b111;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    pwr_mode = 3'b111;
    din = 16'hA5A5;
    din_ovr = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(dout == 8'h00, "R8", "dout in reset", int'(dout), 0);
    chk(!dco && !ovr_out, "R8", "dco/ovr in reset", int'({dco, ovr_out}), 0);
    chk(!smp_take, "R8", "smp_take in reset", int'(smp_take), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input int dsel, input int f, input int sc);
    int dv = dsel + 1;
    int last_clear = -1;
    div_sel = 3'(dsel);
    fmt_tc = (f == 1 || f == 3);
    fmt_gray = (f >= 2);
    do_reset();
    for (int p = 0; p < NP; p++) begin
      logic [2:0] m = mode_for(sc, p);
      bit on = (m == 3'b111);
      bit clr = !(m == 3'b111 || m == 3'b110);
      int j = p - 8;
      bit valid = (j >= 0) && (j > last_clear);
      logic [16:0] ew = valid ? hist[j] : 17'h0;
      string dtag;
      if (!on) dtag = clr ? "R7" : "R6";
      else if (sc == 1 && (j == 9 || j == 10)) dtag = "R6";
      else if (sc >= 2 && j >= 0 && j <= last_clear) dtag = "R7";
      else if (!valid) dtag = "R3";
      else if (f != 0) dtag = "R4";
      else dtag = "R1";
      hist[p] = gen_word(p, dsel, f);
      pwr_mode = m;
      din = hist[p][15:0];
      din_ovr = hist[p][16];
      for (int ph = 0; ph < 2 * dv; ph++) begin
        bit first = (ph < dv);
        logic [7:0] ed = on ? ref_lines(ew[15:0], f, first) : 8'h00;
        #1;
        chk(dout == ed, dtag, "dout", int'(dout), int'(ed));
        chk(dco == (on && first), "R2", "dco", int'(dco), int'(on && first));
        chk(ovr_out == (on && ew[16]), "R5", "ovr_out", int'(ovr_out), int'(on && ew[16]));
        chk(smp_take == (!clr && ph == 2 * dv - 1), "R2", "smp_take", int'(smp_take),
            int'(!clr && ph == 2 * dv - 1));
        @(negedge clk);
      end
      if (clr) last_clear = p;
    end
  endtask

  initial begin
    @(negedge clk);
    for (int d = 0; d < 8; d++)
      for (int f = 0; f < 4; f++)
        for (int sc = 0; sc < 4; sc++)
          run_cfg(d, f, sc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule